// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the word address for a synchronous burst SRAM. On a start cycle it captures an external word address and marks the device as selected. On the cycles that follow it walks the two least significant address bits through a four-word burst, while the upper address bits keep the value captured at the start. Two address strobes can begin a burst. The processor-side strobe only counts when the primary chip enable is also asserted. The controller-side strobe always counts. A start cycle on which the three chip enables are not all active deselects the device instead of selecting it.

Between start cycles an advance input either steps the burst to the next word or holds the current one as a wait cycle. A static select input picks the burst order. In interleaved order the low bits are the start bits XOR the beat count. In linear order they count up modulo four from the start bits. All control inputs are sampled on the rising clock edge. The address output is driven from registered state only.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is: `selected` = 0, `word_addr` = 0 and beat count 0.
- R2: A start cycle is any cycle with `ads_ctrl_n` low, or with `ads_proc_n` low together with `ce_n` low. On a start cycle with all enables active (`ce_n` = 0, `ce_hi` = 1, `ce2_n` = 0), after the edge `word_addr` equals the sampled `addr_in`, `selected` = 1 and the beat count is 0.
- R3: When `ce_n` is high, a low `ads_proc_n` is ignored. With `ads_ctrl_n` high, that cycle is handled exactly as a cycle with no strobe: it advances or holds according to `adv_n`.
- R4: On a start cycle with the enables not all active, `selected` becomes 0. `word_addr` and the beat count stay unchanged.
- R5: With `burst_ilv` = 1 (interleaved), `word_addr[1:0]` equals the start low bits XOR the beat count.
- R6: With `burst_ilv` = 0 (linear), `word_addr[1:0]` equals the start low bits plus the beat count, modulo 4.
- R7: On a cycle with no start and `adv_n` = 0, the beat count increments by one, modulo 4.
- R8: On a cycle with no start and `adv_n` = 1, `word_addr` and `selected` are held.
- R9: `word_addr[ADDR_W-1:2]` changes only on a start cycle that selects. Advancing past the fourth beat wraps within the same four-word block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | External word address, captured on a selecting start |
| ads_proc_n | input | 1 | Processor-side address strobe, active low, gated by `ce_n` |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high gives a wait cycle |
| ce_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Second chip enable, active high |
| ce2_n | input | 1 | Third chip enable, active low |
| burst_ilv | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| word_addr | output | ADDR_W | Current word address |
| selected | output | 1 | Registered device-selected flag |

## Verification
The assertions check the following on every cycle, working from the sampled inputs: the effect of a selecting start, the deselect on a start with an inactive enable, the hold on a wait cycle, the linear step of the low bits, and the rule that the upper bits stay stable outside selecting starts. Some behaviour needs a history of several cycles, and only the bench scenarios can show it. This covers the full interleaved sequence from every start value, the wrap after the fourth beat, the processor strobe being ignored while the primary enable is high, and the sweep over every inactive enable combination with both strobes.

// File: rtl/burst_seq_pkg.sv
// Package: shared constants and the per-cycle action code of the burst sequencer.
package burst_seq_pkg;
    localparam int LOW_W = 2;   // sequenced low address bits (four-word burst)

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,   // wait cycle: nothing moves
        ACT_STEP  = 2'd1,   // advance beat count
        ACT_LOAD  = 2'd2,   // capture new address, select
        ACT_DESEL = 2'd3    // start with an inactive enable: deselect
    } seq_act_e;
endpackage

// File: rtl/burst_ctrl.sv
// burst_ctrl: decodes the sampled strobes, enables and advance input into one
// action per cycle. It is purely combinational. It assumes the caller registers
// the result on the rising edge.
module burst_ctrl
    import burst_seq_pkg::*;
(
    input  logic     ads_proc_n,
    input  logic     ads_ctrl_n,
    input  logic     adv_n,
    input  logic     ce_n,
    input  logic     ce_hi,
    input  logic     ce2_n,
    output seq_act_e act
);
    logic proc_start;
    logic any_start;
    logic all_en;

    // Purpose: form the start condition and the full-enable term.
    always_comb begin
        proc_start = !ads_proc_n && !ce_n;
        any_start  = proc_start || !ads_ctrl_n;
        all_en     = !ce_n && ce_hi && !ce2_n;
    end

    // Purpose: choose the action; a start overrides the advance input.
    always_comb begin
        if (any_start)
            act = all_en ? ACT_LOAD : ACT_DESEL;
        else if (!adv_n)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/burst_counter.sv
// burst_counter: holds the captured start low bits and a separate beat count.
// The count wraps modulo 2**LOW_W and never carries into other bits. It assumes
// a synchronous active-low reset.
module burst_counter
    import burst_seq_pkg::*;
#(
    parameter int CW = LOW_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_act_e      act,
    input  logic [CW-1:0] start_in,
    output logic [CW-1:0] start_q,
    output logic [CW-1:0] cnt_q
);
    // Purpose: update the start bits and the beat count from the cycle action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    start_q <= start_in;
                    cnt_q   <= '0;
                end
                ACT_STEP: cnt_q <= cnt_q + 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/burst_order.sv
// burst_order: maps the start bits and beat count to the low address bits.
// Interleaved order gives start XOR count; linear order gives start + count,
// wrapped. It is combinational and assumes a static order select.
module burst_order #(
    parameter int CW = 2
) (
    input  logic          ilv,
    input  logic [CW-1:0] start_q,
    input  logic [CW-1:0] cnt_q,
    output logic [CW-1:0] low_addr
);
    logic [CW-1:0] ilv_bits;
    logic [CW-1:0] lin_bits;

    // Purpose: interleaved form, built bit by bit.
    genvar b;
    generate
        for (b = 0; b < CW; b++) begin : g_xor
            assign ilv_bits[b] = start_q[b] ^ cnt_q[b];
        end
    endgenerate

    // Purpose: linear form and the order select.
    always_comb begin
        lin_bits = start_q + cnt_q;
        low_addr = ilv ? ilv_bits : lin_bits;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// burst_addr_seq: top of the burst address sequencer. It captures the upper
// address bits and the selected flag on a selecting start, and combines them
// with the sequenced low bits. It assumes ADDR_W > LOW_W and a synchronous
// active-low reset.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              ce_hi,
    input  logic              ce2_n,
    input  logic              burst_ilv,
    output logic [ADDR_W-1:0] word_addr,
    output logic              selected
);
    localparam int UP_W = ADDR_W - LOW_W;

    seq_act_e        act;
    logic [UP_W-1:0] upper_q;
    logic [LOW_W-1:0] start_q;
    logic [LOW_W-1:0] cnt_q;
    logic [LOW_W-1:0] low_addr;
    logic             sel_q;

    burst_ctrl u_ctrl (
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .adv_n      (adv_n),
        .ce_n       (ce_n),
        .ce_hi      (ce_hi),
        .ce2_n      (ce2_n),
        .act        (act)
    );

    burst_counter #(.CW(LOW_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .start_in (addr_in[LOW_W-1:0]),
        .start_q  (start_q),
        .cnt_q    (cnt_q)
    );

    burst_order #(.CW(LOW_W)) u_ord (
        .ilv      (burst_ilv),
        .start_q  (start_q),
        .cnt_q    (cnt_q),
        .low_addr (low_addr)
    );

    // Purpose: capture the upper address bits and track the selected flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            sel_q   <= 1'b0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    upper_q <= addr_in[ADDR_W-1:LOW_W];
                    sel_q   <= 1'b1;
                end
                ACT_DESEL: sel_q <= 1'b0;
                default:   ;
            endcase
        end
    end

    // Purpose: drive the outputs from registered state.
    always_comb begin
        word_addr = {upper_q, low_addr};
        selected  = sel_q;
    end
endmodule

// File: rtl/burst_addr_seq_chk.sv
// burst_addr_seq_chk: cycle-by-cycle properties of the sequencer, written from
// its ports only. It is attached to every instance by the bind below.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              ads_proc_n,
    input logic              ads_ctrl_n,
    input logic              adv_n,
    input logic              ce_n,
    input logic              ce_hi,
    input logic              ce2_n,
    input logic              burst_ilv,
    input logic [ADDR_W-1:0] word_addr,
    input logic              selected
);
    logic start_c;
    logic en_c;

    always_comb begin
        start_c = (!ads_proc_n && !ce_n) || !ads_ctrl_n;
        en_c    = !ce_n && ce_hi && !ce2_n;
    end

    // R1: reset clears the flag and the address
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!selected && word_addr == '0));

    // R2: a selecting start captures the address
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_c && en_c) |=> (selected && word_addr == $past(addr_in)));

    // R4: a start with an inactive enable deselects and keeps the address
    assert_desel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_c && !en_c) |=> (!selected && $stable(word_addr)));

    // R8: a wait cycle holds the address and the flag
    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_c && adv_n && $stable(burst_ilv)) |=> ($stable(word_addr) && $stable(selected)));

    // R6: a linear step adds one to the low bits
    assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_c && !adv_n && !burst_ilv) ##1 !burst_ilv |->
        word_addr[1:0] == 2'($past(word_addr[1:0]) + 2'd1));

    // R9: upper bits move only on a selecting start
    assert_upper_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_c && en_c) |=> $stable(word_addr[ADDR_W-1:2]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_in    (addr_in),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .ce_n       (ce_n),
    .ce_hi      (ce_hi),
    .ce2_n      (ce2_n),
    .burst_ilv  (burst_ilv),
    .word_addr  (word_addr),
    .selected   (selected)
);

// File: tb/burst_addr_seq_test.sv
// Bench for burst_addr_seq. It sweeps both orders, all start values and both
// strobes, then the enable combinations. Expected values are computed here.
module burst_addr_seq_test;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
    logic          ce_n = 1'b1, ce_hi = 1'b0, ce2_n = 1'b1, burst_ilv = 1'b1;
    logic [AW-1:0] word_addr;
    logic          selected;

    int n_chk = 0, n_bad = 0;
    logic          done = 1'b0;

    // expected state
    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_st = '0, m_cnt = '0;
    logic          m_sel = 1'b0;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
        .ce_n(ce_n), .ce_hi(ce_hi), .ce2_n(ce2_n), .burst_ilv(burst_ilv),
        .word_addr(word_addr), .selected(selected)
    );

    always #5 clk = ~clk;

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = burst_ilv ? (m_st ^ m_cnt) : 2'(m_st + m_cnt);
        return {m_up, lo};
    endfunction

    task automatic check(input string tag);
        n_chk++;
        if (word_addr !== exp_addr() || selected !== m_sel) begin
            n_bad++;
            $display("FAIL %s: addr=%h sel=%b expected addr=%h sel=%b",
                     tag, word_addr, selected, exp_addr(), m_sel);
        end
    endtask

    // one clock: drive at the falling edge, update the model, check at next fall
    task automatic cyc(input logic [AW-1:0] a, input logic pn, input logic cn,
                       input logic avn, input logic e0n, input logic e1,
                       input logic e2n, input string tag);
        logic st, en;
        addr_in = a; ads_proc_n = pn; ads_ctrl_n = cn; adv_n = avn;
        ce_n = e0n; ce_hi = e1; ce2_n = e2n;
        @(posedge clk);
        st = (!pn && !e0n) || !cn;
        en = !e0n && e1 && !e2n;
        if (!rst_n) begin
            m_up = '0; m_st = '0; m_cnt = '0; m_sel = 1'b0;
        end else if (st) begin
            if (en) begin
                m_up = a[AW-1:2]; m_st = a[1:0]; m_cnt = '0; m_sel = 1'b1;
            end else m_sel = 1'b0;
        end else if (!avn) m_cnt = m_cnt + 2'd1;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc('0, 1, 1, 1, 1, 0, 1, "R1 reset");
        cyc(10'h3FF, 1, 0, 0, 0, 1, 0, "R1 reset beats strobe");
        rst_n = 1'b1;

        // Order, start value and strobe sweep with wait cycles and wrap.
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                for (int v = 0; v < 2; v++) begin
                    logic [AW-1:0] a;
                    burst_ilv = o[0];
                    a = AW'((o * 97 + s * 41 + v * 13 + 5) << 2) | AW'(s);
                    if (v == 0) cyc(a, 0, 1, 1, 0, 1, 0, "R3 proc strobe load R2");
                    else        cyc(a, 1, 0, 1, 0, 1, 0, "R2 ctrl strobe load");
                    for (int k = 0; k < 7; k++) begin
                        cyc(a ^ 10'h155, 1, 1, 0, 1, 0, 1,
                            o[0] ? "R5 interleaved step R7 R9" : "R6 linear step R7 R9");
                        if (k == 2) cyc(a, 1, 1, 1, 0, 1, 0, "R8 wait cycle");
                    end
                end
            end
        end

        // Processor strobe ignored while the primary enable is high.
        burst_ilv = 1'b0;
        cyc(10'h2C9, 1, 0, 1, 0, 1, 0, "R2 reload");
        cyc(10'h0F0, 0, 1, 0, 1, 1, 0, "R3 proc ignored advances");
        cyc(10'h0F0, 0, 1, 1, 1, 1, 0, "R3 proc ignored holds");
        cyc(10'h0F0, 0, 1, 0, 1, 0, 1, "R3 proc ignored advances again");

        // Every inactive enable combination, through both strobes.
        for (int e = 0; e < 8; e++) begin
            if (e != 3'b010) begin
                cyc(10'h1A6, 1, 0, 1, 0, 1, 0, "R2 reselect");
                cyc(10'h39B, 1, 0, 1, e[2], e[1], e[0], "R4 ctrl deselect");
                cyc(10'h39B, 1, 1, 1, e[2], e[1], e[0], "R8 hold while deselected");
                if (!e[2]) begin
                    cyc(10'h1A6, 1, 0, 1, 0, 1, 0, "R2 reselect");
                    cyc(10'h05C, 0, 1, 1, e[2], e[1], e[0], "R4 proc deselect");
                end
            end
        end

        // Reset in the middle of a burst.
        cyc(10'h2EF, 1, 0, 0, 0, 1, 0, "R2 load before reset");
        rst_n = 1'b0;
        cyc(10'h2EF, 1, 1, 0, 1, 0, 1, "R1 reset mid-burst");
        rst_n = 1'b1;
        cyc(10'h2EF, 1, 1, 1, 1, 0, 1, "R1 stays clear after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule